// File: doc/BRIEF.md
# Two-Wire Serial Slave for a Paged Register and Lookup-Table Array

This block is a serial slave on a two-wire bus, made of a clock line and an open-drain data line. It gives a bus master read and write access to a 144-byte array. The array sits at byte addresses 080h to 10Fh and is split into 9 pages of 16 bytes. The first page holds control registers, with a reserved range in its upper half. The next four pages form the first lookup table (090h to 0CFh). The last four pages form the second lookup table (0D0h to 10Fh). The array is held in flip-flops and clears to zero at reset.

The block oversamples both bus lines on its own system clock and finds START and STOP conditions. A transaction opens with a slave address byte. The block answers only when the fixed type nibble and three strap inputs match that byte. In a write, the next byte sets the word address and later bytes are stored. In a read, bytes come back from the current pointer until the master declines one. The pointer advances after every byte and stays inside its 16-byte page. A write-enable latch in the control register gates every write. Reserved registers and reserved bits cannot be changed.

Top module: `tw_mem_slave`

## Requirements
- R1: After a START, the slave address byte is acknowledged only if bits 7:4 equal 1010b and bits 3:1 equal `devStrap[2:0]`; bit 0 selects read (1) or write (0). Any other byte gets no acknowledge, and the slave then ignores the bus until the next START.
- R2: Bytes move most significant bit first in both directions. The slave pulls SDA low (`sdaOe`=1) during the ninth clock to acknowledge each byte it accepts. It changes `sdaOe` only while SCL is low, and it never drives SDA while the master sends data bits.
- R3: The word address byte gives the low 8 address bits. Address bit 8 is control bit 0 of register 087h (page select) ANDed with the inverse of byte bit 7. Data written to an address outside 080h–10Fh gets no acknowledge and is not stored. Reads from such an address return 00h.
- R4: Bit 7 of 087h is the write-enable latch. A write to 087h always updates that bit. Every other stored bit changes only if the latch was already 1 before the byte arrived. Writes that are refused this way are still acknowledged.
- R5: Addresses 088h–08Fh are reserved. Data written to them is acknowledged and discarded, and reads from them return 00h.
- R6: Bits 7:6 of registers 080h–086h and bits 6:1 of 087h are reserved and always store 0.
- R7: After each byte written or read, the pointer's low 4 bits advance by one and wrap from Fh to 0h. The upper address bits stay the same.
- R8: In a read, the slave sends bytes from the pointer. A master acknowledge (SDA low on the ninth clock) asks for the next byte. A master no-acknowledge ends the transfer, and the slave leaves SDA released until the next START.
- R9: A STOP or a repeated START at any point returns the slave to idle, or to address reception for a START. A partly received byte is dropped without being written.
- R10: After reset every array byte is 00h, `sdaOe` is 0, and the pointer is 080h, so a read with no word address returns the byte at 080h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level as seen on the wire |
| devStrap | input | 3 | Strap-selected device address bits |
| sdaOe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong pointer or cell value shows up at the ports within one byte time. The next read either returns a byte that differs from the bench model, or the acknowledge of the next data write flips, because the validity of the address decides the acknowledge. A wrong control state shows within one bus clock: an acknowledge is missing, or SDA is pulled low while the master sends a 1. The bench also reads each protected byte back, so a latch or reserved-bit fault appears as a data mismatch in the next read transaction.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } busState_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WORD,
    PH_DATA
  } phase_t;

  typedef struct packed {
    logic shiftIn;
    logic loadAddr;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/tw_mem_dp.sv
module tw_mem_dp
  import tw_mem_pkg::*;
#(
  parameter int PAGE_BYTES    = 16,
  parameter int NUM_PAGES     = 9,
  parameter int BASE_ADDR     = 128,
  parameter int CTRL_IDX      = 7,
  parameter int WEL_BIT       = 7,
  parameter int PSEL_BIT      = 0,
  parameter int RSV_FIRST     = 8,
  parameter int RSV_LAST      = 15,
  parameter logic [7:0] REG_RSV_MASK  = 8'hC0,
  parameter logic [7:0] CTRL_RSV_MASK = 8'h7E,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strb,
  output logic              sclLevel,
  output logic              sdaLevel,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic [BYTE_W-1:0] rxByte,
  output logic              addrValid,
  output logic              txBit
);
  localparam int DEPTH  = PAGE_BYTES * NUM_PAGES;
  localparam int ADDR_W = BYTE_W + 1;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(BASE_ADDR + DEPTH);

  // Line synchronisers and edge detection
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclLevel;
      sdaPrev <= sdaLevel;
    end
  end

  assign sclLevel = sclSync[SYNC_STAGES-1];
  assign sdaLevel = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;
  assign startDet = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign stopDet  = sclLevel & sclPrev & ~sdaPrev & sdaLevel;

  // Receive shifter
  logic [BYTE_W-1:0] rxShift;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaLevel};
  end
  assign rxByte = rxShift;

  // Array and control bits
  logic [BYTE_W-1:0] mem [DEPTH];
  logic welBit, pselBit;
  assign welBit  = mem[CTRL_IDX][WEL_BIT];
  assign pselBit = mem[CTRL_IDX][PSEL_BIT];

  // Address pointer with in-page increment
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] idxFull;
  logic              stepPtr;
  assign idxFull   = ptr - BASE_A;
  assign addrValid = (ptr >= BASE_A) && (ptr < LIMIT_A);
  assign stepPtr   = strb.writeByte | strb.loadTx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= BASE_A;
    else if (strb.loadAddr) ptr <= {pselBit & ~rxShift[BYTE_W-1], rxShift};
    else if (stepPtr) ptr <= {ptr[ADDR_W-1:OFF_W], ptr[OFF_W-1:0] + OFF_W'(1)};
  end

  // Next value for the control register: latch bit always, the rest gated
  logic [BYTE_W-1:0] ctrlNext;
  always_comb begin
    ctrlNext = welBit ? rxShift : mem[CTRL_IDX];
    ctrlNext = ctrlNext & ~CTRL_RSV_MASK;
    ctrlNext[WEL_BIT] = rxShift[WEL_BIT];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gCell
    if (g == CTRL_IDX) begin : gCtrl
      logic hit;
      assign hit = strb.writeByte && addrValid && (idxFull == ADDR_W'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mem[g] <= '0;
        else if (hit) mem[g] <= ctrlNext;
      end
    end else if (g >= RSV_FIRST && g <= RSV_LAST) begin : gRsv
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mem[g] <= '0;
        else mem[g] <= '0;
      end
    end else begin : gData
      logic hit;
      assign hit = strb.writeByte && addrValid && (idxFull == ADDR_W'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) mem[g] <= '0;
        else if (hit && welBit) mem[g] <= (g < CTRL_IDX) ? (rxShift & ~REG_RSV_MASK) : rxShift;
      end
      AST_WEL_GUARD: assert property (@(posedge clk) disable iff (!rstN)
        (hit && !welBit) |=> $stable(mem[g])); // R4
    end
  end

  // Transmit shifter
  logic [BYTE_W-1:0] rdData;
  logic [BYTE_W-1:0] txShift;
  assign rdData = addrValid ? mem[idxFull[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= '0;
    else if (strb.loadTx) txShift <= rdData;
    else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
  end
  assign txBit = txShift[BYTE_W-1];

  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stepPtr && !strb.loadAddr) |=> (ptr[ADDR_W-1:OFF_W] == $past(ptr[ADDR_W-1:OFF_W]))); // R7
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stepPtr && !strb.loadAddr && (ptr[OFF_W-1:0] == '1)) |=> (ptr[OFF_W-1:0] == '0)); // R7
  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx && addrValid && idxFull >= ADDR_W'(RSV_FIRST) && idxFull <= ADDR_W'(RSV_LAST))
      |=> (txShift == '0)); // R5
  AST_RSV_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (mem[CTRL_IDX] & CTRL_RSV_MASK) == '0); // R6
endmodule

// File: rtl/tw_mem_ctrl.sv
module tw_mem_ctrl
  import tw_mem_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter int STRAP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclLevel,
  input  logic              sdaLevel,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              addrValid,
  input  logic              txBit,
  input  logic [STRAP_W-1:0] devStrap,
  output dpStrobe_t         strb,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  busState_t       state, stateNext;
  phase_t          phase, phaseNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic            readMode, readNext;
  logic            mAck, mAckNext;
  logic            devMatch;

  assign devMatch = (rxByte[BYTE_W-1:BYTE_W-4] == DEV_TYPE) &&
                    (rxByte[STRAP_W:1] == devStrap);

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    cntNext   = bitCnt;
    readNext  = readMode;
    mAckNext  = mAck;
    strb      = '0;
    if (startDet) begin
      stateNext = ST_RX;
      phaseNext = PH_DEV;
      cntNext   = '0;
    end else if (stopDet) begin
      stateNext = ST_IDLE;
      cntNext   = '0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt < LAST_BIT) begin
            strb.shiftIn = 1'b1;
            cntNext = bitCnt + CNT_W'(1);
          end else if (sclFall && bitCnt == LAST_BIT) begin
            cntNext = '0;
            case (phase)
              PH_DEV: begin
                if (devMatch) begin
                  stateNext = ST_ACK;
                  readNext  = rxByte[0];
                end else begin
                  stateNext = ST_IDLE;
                end
              end
              PH_WORD: begin
                strb.loadAddr = 1'b1;
                stateNext = ST_ACK;
              end
              default: begin
                if (addrValid) begin
                  strb.writeByte = 1'b1;
                  stateNext = ST_ACK;
                end else begin
                  stateNext = ST_IDLE;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            cntNext = '0;
            if (phase == PH_DEV && readMode) begin
              strb.loadTx = 1'b1;
              stateNext = ST_TX;
            end else begin
              stateNext = ST_RX;
              phaseNext = (phase == PH_DEV) ? PH_WORD : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            cntNext = bitCnt + CNT_W'(1);
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) stateNext = ST_MACK;
            else strb.shiftTx = 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            mAckNext = ~sdaLevel;
          end else if (sclFall) begin
            cntNext = '0;
            if (mAck) begin
              strb.loadTx = 1'b1;
              stateNext = ST_TX;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_DEV;
      bitCnt   <= '0;
      readMode <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      state    <= stateNext;
      phase    <= phaseNext;
      bitCnt   <= cntNext;
      readMode <= readNext;
      mAck     <= mAckNext;
    end
  end

  assign sdaOe = (state == ST_ACK) || (state == ST_TX && !txBit);

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLevel); // R2
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE && !sdaOe)); // R9
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_RX && phase == PH_DEV && bitCnt == '0)); // R9
  AST_TYPE_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX && phase == PH_DEV && sclFall && !startDet && !stopDet &&
     bitCnt == LAST_BIT && rxByte[BYTE_W-1:BYTE_W-4] != DEV_TYPE) |=> (state == ST_IDLE)); // R1
  AST_NO_DRIVE_IN_RX: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX) |-> !sdaOe); // R2
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tw_mem_pkg::*;
#(
  parameter int PAGE_BYTES  = 16,
  parameter int NUM_PAGES   = 9,
  parameter int BASE_ADDR   = 128,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] devStrap,
  output logic               sdaOe
);
  dpStrobe_t         strb;
  logic              sclLevel, sdaLevel, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic              addrValid, txBit;

  tw_mem_dp #(
    .PAGE_BYTES(PAGE_BYTES),
    .NUM_PAGES(NUM_PAGES),
    .BASE_ADDR(BASE_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .strb(strb),
    .sclLevel(sclLevel),
    .sdaLevel(sdaLevel),
    .sclRise(sclRise),
    .sclFall(sclFall),
    .startDet(startDet),
    .stopDet(stopDet),
    .rxByte(rxByte),
    .addrValid(addrValid),
    .txBit(txBit)
  );

  tw_mem_ctrl #(
    .STRAP_W(STRAP_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sclLevel(sclLevel),
    .sdaLevel(sdaLevel),
    .sclRise(sclRise),
    .sclFall(sclFall),
    .startDet(startDet),
    .stopDet(stopDet),
    .rxByte(rxByte),
    .addrValid(addrValid),
    .txBit(txBit),
    .devStrap(devStrap),
    .strb(strb),
    .sdaOe(sdaOe)
  );
endmodule

// File: tb/test_tw_mem_slave.sv
module test_tw_mem_slave;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sdaOe;
  logic       sdaBus;
  assign sdaBus = mSda & ~sdaOe;

  always #10 clk = ~clk;

  tw_mem_slave i_tw_mem_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .devStrap(strap), .sdaOe(sdaOe)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural reference: byte array indexed from 080h, plus pointer
  logic [7:0] mdl [144];
  int mPtr = 128;
  logic [7:0] wq [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit mValid(input int p);
    return p >= 128 && p < 272;
  endfunction

  function automatic logic [7:0] mRead(input int p);
    if (!mValid(p) || (p >= 136 && p <= 143)) return 8'h00;
    return mdl[p - 128];
  endfunction

  task automatic mWrite(input logic [7:0] d);
    int  idx = mPtr - 128;
    bit  wel = mdl[7][7];
    if (idx == 7) mdl[7] = {d[7], 6'b0, wel ? d[0] : mdl[7][0]};
    else if (idx < 7) begin if (wel) mdl[idx] = d & 8'h3F; end
    else if (idx >= 8 && idx <= 15) begin end
    else if (wel) mdl[idx] = d;
  endtask

  task automatic mInc();
    mPtr = (mPtr & ~15) | ((mPtr + 1) & 15);
  endtask

  task automatic mSetAddr(input logic [7:0] b);
    mPtr = (mdl[7][0] && !b[7]) ? 256 + int'(b) : int'(b);
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitCycle(input bit d, output bit s);
    mSda = d; waitQ();
    mScl = 1'b1; waitQ();
    s = sdaBus; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic startCond();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    bit s;
    int bad = 0;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(b[i], s);
      if (s != b[i]) bad++;
    end
    chk(bad == 0, "R2 no slave drive on data bits", bad, 0);
    bitCycle(1'b1, s);
    chk(s == !expAck, req, int'(!s), int'(expAck));
  endtask

  task automatic readByte(input logic [7:0] expB, input bit ack, input string req);
    bit s;
    logic [7:0] v = '0;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s);
      v = {v[6:0], s};
    end
    chk(v == expB, req, int'(v), int'(expB));
    bitCycle(!ack, s);
  endtask

  function automatic logic [7:0] devByte(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic writeTxn(input logic [7:0] addr, input string req);
    startCond();
    sendByte(devByte(1'b0), 1'b1, "R1 device ack (write)");
    sendByte(addr, 1'b1, "R3 word address ack");
    mSetAddr(addr);
    foreach (wq[k]) begin
      bit ok = mValid(mPtr);
      sendByte(wq[k], ok, req);
      if (!ok) break;
      mWrite(wq[k]);
      mInc();
    end
    stopCond();
  endtask

  task automatic readTail(input int n, input string req);
    bit s;
    for (int k = 0; k < n; k++) begin
      readByte(mRead(mPtr), k < n - 1, req);
      mInc();
    end
    bitCycle(1'b1, s);
    chk(s == 1'b1, "R8 released after master NACK", int'(s), 1);
    stopCond();
  endtask

  task automatic readTxn(input logic [7:0] addr, input int n, input string req);
    startCond();
    sendByte(devByte(1'b0), 1'b1, "R1 device ack (write)");
    sendByte(addr, 1'b1, "R3 word address ack");
    mSetAddr(addr);
    startCond();
    sendByte(devByte(1'b1), 1'b1, "R1 device ack (read)");
    readTail(n, req);
  endtask

  task automatic abortTxn(input logic [7:0] addr, input logic [7:0] d, input bit useStart);
    bit s;
    startCond();
    sendByte(devByte(1'b0), 1'b1, "R1 device ack (write)");
    sendByte(addr, 1'b1, "R3 word address ack");
    mSetAddr(addr);
    for (int i = 7; i >= 3; i--) bitCycle(d[i], s);
    if (useStart) begin
      startCond();
      sendByte(devByte(1'b1), 1'b1, "R9 restart then device ack");
      readTail(1, "R9 aborted byte not written (restart)");
    end else begin
      stopCond();
      readTxn(addr, 1, "R9 aborted byte not written (stop)");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (mdl[k]) mdl[k] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(sdaOe == 1'b0, "R10 sdaOe low after reset", int'(sdaOe), 0);

    // R10: current-address read starts at 080h
    startCond();
    sendByte(devByte(1'b1), 1'b1, "R1 device ack (read)");
    readTail(2, "R10 reset contents and pointer");

    // R1: wrong strap, wrong type
    startCond();
    sendByte({4'b1010, strap ^ 3'b001, 1'b0}, 1'b0, "R1 strap mismatch NACK");
    sendByte(8'h90, 1'b0, "R1 ignored after mismatch");
    stopCond();
    startCond();
    sendByte({4'b1011, strap, 1'b1}, 1'b0, "R1 type mismatch NACK");
    stopCond();

    // R4: write without latch
    wq = '{8'h55};
    writeTxn(8'h90, "R4 write without latch acked");
    readTxn(8'h90, 1, "R4 write without latch discarded");

    // R4/R6: set latch, reserved bits
    wq = '{8'h80};
    writeTxn(8'h87, "R4 latch set acked");
    wq = '{8'hFF};
    writeTxn(8'h80, "R6 register write");
    wq = '{8'hFF};
    writeTxn(8'h86, "R6 register write");
    wq = '{8'hFF};
    writeTxn(8'h87, "R6 control write");
    readTxn(8'h80, 8, "R6 reserved bits read zero");

    // R3/R7: page select to upper page, wrap
    wq = '{8'hA5, 8'h5A};
    writeTxn(8'h0F, "R3 upper page write");
    readTxn(8'h0F, 3, "R7 upper page wrap read");
    wq = '{8'h11};
    writeTxn(8'h20, "R3 out-of-range write NACK");
    readTxn(8'h30, 1, "R3 out-of-range read zero");

    // R7: lookup table burst wrap
    wq = '{8'h11, 8'h22, 8'h33, 8'h44};
    writeTxn(8'h9E, "R7 burst write");
    readTxn(8'h9E, 4, "R7 burst wrap read");
    wq = '{8'hC3, 8'h3C};
    writeTxn(8'hFE, "R7 second table write");
    readTxn(8'hF0, 1, "R7 second table wrap");

    // R5: reserved range
    wq = '{8'h77};
    writeTxn(8'h8A, "R5 reserved write acked");
    readTxn(8'h8A, 1, "R5 reserved read zero");
    readTxn(8'h86, 3, "R5 burst into reserved");

    // R9: aborts
    abortTxn(8'h95, 8'hE7, 1'b0);
    abortTxn(8'hA0, 8'hB6, 1'b1);

    // R4: clear latch, then writes ignored
    wq = '{8'h00};
    writeTxn(8'h87, "R4 latch clear");
    wq = '{8'h99};
    writeTxn(8'hA5, "R4 write after clear acked");
    readTxn(8'hA5, 1, "R4 write after clear discarded");
    wq = '{8'h01};
    writeTxn(8'h87, "R4 page select held without latch");
    readTxn(8'h87, 1, "R4 control byte without latch");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule